// File: doc/BRIEF.md
# External Interrupt and Keyboard Wake Controller

This block produces the maskable external interrupt request of a small 8-bit processor. A dedicated active-low request pin is merged with a group of keyboard pins. The keyboard pins count as active when high, so they act as inverted copies of the request pin. A separate auxiliary pin has its own falling-edge interrupt path, with its own flag and request output. Two static configuration inputs select the options that would otherwise be fixed at manufacture. One chooses edge-only or edge-plus-level sensitivity. The other decides whether the keyboard pins take part.

Every pin is asynchronous and passes through a two-flop synchroniser. The main path forms one combined active signal after synchronisation and inversion. A rising edge of that signal sets a pending flag. The auxiliary path sets its own flag on a falling edge of its pin. Software reaches two small control registers through a plain write strobe, a select bit and a combinational read port. Each register holds an enable bit, the flag (read only) and an acknowledge bit (write one to clear, always reads as zero). The block carries no data stream, so it has no valid/ready handshake. Every port is plain control or status.

Top module: `ext_irq_kbd`

## Requirements
- R1: After reset both enable bits, both flags and both request outputs are 0, and both registers read 0. All pins are taken as inactive inputs.
- R2: A falling edge on `irq_pin_n` sets the main flag (bit 1 of register 0). The flag first reads 1 after the third rising clock edge that follows the pin change, and not after the second. With the main enable (bit 0) set, `irq_req` rises on that same edge.
- R3: With `cfg_level_mode`=1, `irq_req` is high whenever the main enable is set and the combined input is active. This starts two clock edges after the pin change and stays high after an acknowledge. With `cfg_level_mode`=0, a held active level does not drive `irq_req` after the flag has been acknowledged.
- R4: With `cfg_kbd_en`=1, a rising edge or a high level on any `kbd_pins` bit acts like a falling edge or a low level on `irq_pin_n`, in either sensitivity mode. With `cfg_kbd_en`=0 the keyboard pins have no effect.
- R5: Simultaneous activity on several keyboard pins and the request pin yields one pending event, which one acknowledge clears. An edge on a further pin while the combined input is already active creates no new event.
- R6: Writing 1 to bit 2 of a register clears that register's flag, and bit 2 always reads 0. If an edge and the acknowledge fall in the same cycle, the flag stays set.
- R7: A source whose enable bit is 0 still sets its flag but keeps its request output low. Setting the enable later raises the request if the flag is still pending.
- R8: A falling edge on `aux_pin` sets the auxiliary flag (bit 1 of register 1) and, when enabled, `aux_req`. A rising edge does not. The auxiliary path ignores `cfg_level_mode` and `cfg_kbd_en`, and its edges leave the main flag untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_level_mode | input | 1 | 1: edge plus level sensitivity on the main path; 0: edge only |
| cfg_kbd_en | input | 1 | 1: keyboard pins join the main path |
| irq_pin_n | input | 1 | Asynchronous active-low request pin |
| kbd_pins | input | KBD_W | Asynchronous keyboard pins, active high |
| aux_pin | input | 1 | Asynchronous auxiliary pin, falling-edge source |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: main register, 1: auxiliary register |
| reg_wdata | input | 3 | Write data: bit 0 enable, bit 2 acknowledge |
| reg_rdata | output | 3 | Read data: bit 0 enable, bit 1 flag, bit 2 zero |
| irq_req | output | 1 | Main interrupt request |
| aux_req | output | 1 | Auxiliary interrupt request |

## Verification
The case that needs care is edge capture and software acknowledge arriving in the same cycle on the same flag. The bench first sets the flag and releases the pin. It then makes a new edge and issues the acknowledge write exactly two clock edges after the pin change. That places the write on the cycle in which the synchronised edge is detected. The flag must still read 1 afterwards, and a later acknowledge on its own must clear it. This is done for both the main and the auxiliary paths.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int CTL_W    = 3;
  localparam int BIT_EN   = 0;
  localparam int BIT_FLAG = 1;
  localparam int BIT_ACK  = 2;
  localparam int NSRC     = 2;
  localparam int SRC_MAIN = 0;
  localparam int SRC_AUX  = 1;

  typedef struct packed {
    logic en;
    logic ack;
  } src_ctl_t;
endpackage

// File: rtl/eik_sync.sv
module eik_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign q_sync = stage2;
endmodule

// File: rtl/eik_pending.sv
module eik_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic ack,
  output logic hit,
  output logic pend
);
  logic act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end

  assign hit = act & ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (hit) pend <= 1'b1;
    else if (ack) pend <= 1'b0;
  end
endmodule

// File: rtl/eik_ctl_reg.sv
module eik_ctl_reg
  import ext_irq_pkg::*;
#(
  parameter int SEL = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  logic     sel,
  input  logic     wr_en_bit,
  input  logic     wr_ack_bit,
  output src_ctl_t ctl
);
  logic hit_me;
  logic en_q;

  assign hit_me = wr && (sel == SEL[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (hit_me) en_q <= wr_en_bit;
  end

  assign ctl.en  = en_q;
  assign ctl.ack = hit_me & wr_ack_bit;
endmodule

// File: rtl/ext_irq_kbd.sv
module ext_irq_kbd
  import ext_irq_pkg::*;
#(
  parameter int KBD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_level_mode,
  input  logic             cfg_kbd_en,
  input  logic             irq_pin_n,
  input  logic [KBD_W-1:0] kbd_pins,
  input  logic             aux_pin,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CTL_W-1:0] reg_wdata,
  output logic [CTL_W-1:0] reg_rdata,
  output logic             irq_req,
  output logic             aux_req
);
  localparam int PIN_W = KBD_W + 2;

  logic [PIN_W-1:0] pins_raw;
  logic [PIN_W-1:0] pins_s;
  logic             irq_s_n;
  logic [KBD_W-1:0] kbd_s;
  logic             aux_s;

  assign pins_raw = {aux_pin, kbd_pins, irq_pin_n};

  eik_sync #(
    .W       (PIN_W),
    .RST_VAL ({1'b1, {KBD_W{1'b0}}, 1'b1})
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pins_raw),
    .q_sync  (pins_s)
  );

  assign irq_s_n = pins_s[0];
  assign kbd_s   = pins_s[KBD_W:1];
  assign aux_s   = pins_s[PIN_W-1];

  logic [NSRC-1:0] src_act;
  logic [NSRC-1:0] src_hit;
  logic [NSRC-1:0] src_pend;
  src_ctl_t        src_ctl [NSRC];

  assign src_act[SRC_MAIN] = ~irq_s_n | (cfg_kbd_en & (|kbd_s));
  assign src_act[SRC_AUX]  = ~aux_s;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    eik_ctl_reg #(.SEL(i)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .sel        (reg_sel),
      .wr_en_bit  (reg_wdata[BIT_EN]),
      .wr_ack_bit (reg_wdata[BIT_ACK]),
      .ctl        (src_ctl[i])
    );
    eik_pending u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (src_act[i]),
      .ack   (src_ctl[i].ack),
      .hit   (src_hit[i]),
      .pend  (src_pend[i])
    );
  end

  logic main_hit, main_pend, main_ack, main_en, main_act;
  logic aux_hit, aux_pend, aux_ack, aux_en;

  assign main_hit  = src_hit[SRC_MAIN];
  assign main_pend = src_pend[SRC_MAIN];
  assign main_ack  = src_ctl[SRC_MAIN].ack;
  assign main_en   = src_ctl[SRC_MAIN].en;
  assign main_act  = src_act[SRC_MAIN];
  assign aux_hit   = src_hit[SRC_AUX];
  assign aux_pend  = src_pend[SRC_AUX];
  assign aux_ack   = src_ctl[SRC_AUX].ack;
  assign aux_en    = src_ctl[SRC_AUX].en;

  assign irq_req = main_en & (main_pend | (cfg_level_mode & main_act));
  assign aux_req = aux_en & aux_pend;

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == 1'b0) begin
      reg_rdata[BIT_EN]   = main_en;
      reg_rdata[BIT_FLAG] = main_pend;
    end else begin
      reg_rdata[BIT_EN]   = aux_en;
      reg_rdata[BIT_FLAG] = aux_pend;
    end
  end
endmodule

// File: rtl/eik_checker.sv
module eik_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_level_mode,
  input logic       irq_req,
  input logic       aux_req,
  input logic [2:0] reg_rdata,
  input logic       main_hit,
  input logic       main_pend,
  input logic       main_ack,
  input logic       main_en,
  input logic       main_act,
  input logic       aux_hit,
  input logic       aux_pend,
  input logic       aux_ack,
  input logic       aux_en
);
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!irq_req && !aux_req && !main_pend && !aux_pend);
    end
  end

  p_edge_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    main_hit |=> main_pend);

  p_level_drives_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_level_mode && main_en && main_act |-> irq_req);

  p_edge_mode_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_level_mode && irq_req |-> main_pend);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    main_ack && !main_hit |=> !main_pend);

  p_flag_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    main_pend && !main_ack |=> main_pend);

  p_ack_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[2] == 1'b0);

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !main_en |-> !irq_req);

  p_aux_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_en |-> !aux_req);

  p_aux_edge_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    aux_hit |=> aux_pend);

  p_aux_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    aux_ack && !aux_hit |=> !aux_pend);
endmodule

bind ext_irq_kbd eik_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_level_mode (cfg_level_mode),
  .irq_req        (irq_req),
  .aux_req        (aux_req),
  .reg_rdata      (reg_rdata),
  .main_hit       (main_hit),
  .main_pend      (main_pend),
  .main_ack       (main_ack),
  .main_en        (main_en),
  .main_act       (main_act),
  .aux_hit        (aux_hit),
  .aux_pend       (aux_pend),
  .aux_ack        (aux_ack),
  .aux_en         (aux_en)
);

// File: tb/ext_irq_kbd_test.sv
`timescale 1ns/1ps
module ext_irq_kbd_test;
  localparam int KBD_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_level_mode = 1'b0;
  logic             cfg_kbd_en = 1'b0;
  logic             irq_pin_n = 1'b1;
  logic [KBD_W-1:0] kbd_pins = '0;
  logic             aux_pin = 1'b1;
  logic             reg_wr = 1'b0;
  logic             reg_sel = 1'b0;
  logic [2:0]       reg_wdata = '0;
  logic [2:0]       reg_rdata;
  logic             irq_req;
  logic             aux_req;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ext_irq_kbd #(.KBD_W(KBD_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_level_mode(cfg_level_mode),
    .cfg_kbd_en(cfg_kbd_en), .irq_pin_n(irq_pin_n), .kbd_pins(kbd_pins),
    .aux_pin(aux_pin), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .aux_req(aux_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [2:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic s, output logic [2:0] d);
    reg_sel = s;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_pin_n = 1'b1; kbd_pins = '0; aux_pin = 1'b1;
    reg_wr = 1'b0; reg_wdata = '0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  // src 0: request pin, 1..KBD_W: keyboard pin src-1, KBD_W+1: aux pin
  task automatic drive(input int src, input logic v);
    if (src == 0) irq_pin_n = ~v;
    else if (src <= KBD_W) kbd_pins[src-1] = v;
    else aux_pin = ~v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [2:0] d;
    // R1 reset state
    do_reset();
    rd(1'b0, d); check("R1 main reg", d, 0);
    rd(1'b1, d); check("R1 aux reg", d, 0);
    check("R1 irq_req", irq_req, 0);
    check("R1 aux_req", aux_req, 0);

    // sweep every configuration against every source
    for (int lvl = 0; lvl < 2; lvl++) begin
      for (int ke = 0; ke < 2; ke++) begin
        for (int src = 0; src < KBD_W + 2; src++) begin
          bit trig, isaux;
          trig  = (src == 0) || (ke == 1 && src >= 1 && src <= KBD_W);
          isaux = (src == KBD_W + 1);
          cfg_level_mode = lvl[0]; cfg_kbd_en = ke[0];
          do_reset();
          wr(1'b0, 3'b001); wr(1'b1, 3'b001);
          drive(src, 1'b1);
          tick(2);
          check("R3 R4 level request at two edges", irq_req, int'(lvl == 1 && trig));
          rd(1'b0, d); check("R2 flag not yet set", d[1], 0);
          tick(1);
          rd(1'b0, d); check("R2 R4 main flag", d[1], int'(trig));
          check("R2 irq_req", irq_req, int'(trig));
          rd(1'b1, d); check("R8 aux flag", d[1], int'(isaux));
          check("R8 aux_req", aux_req, int'(isaux));
          wr(1'b0, 3'b101); wr(1'b1, 3'b101);
          rd(1'b0, d);
          check("R6 main flag cleared", d[1], 0);
          check("R6 ack reads zero", d[2], 0);
          check("R3 held level after ack", irq_req, int'(lvl == 1 && trig));
          rd(1'b1, d); check("R6 aux flag cleared", d[1], 0);
          drive(src, 1'b0);
          tick(4);
          check("R3 released request", irq_req, 0);
          rd(1'b0, d); check("R4 no flag on release", d[1], 0);
          rd(1'b1, d); check("R8 rising edge ignored", d[1], 0);
        end
      end
    end

    // R7 disabled sources latch but stay quiet
    cfg_level_mode = 1'b0; cfg_kbd_en = 1'b0;
    do_reset();
    irq_pin_n = 1'b0; aux_pin = 1'b0;
    tick(3);
    rd(1'b0, d); check("R7 main flag while disabled", d[1], 1);
    rd(1'b1, d); check("R7 aux flag while disabled", d[1], 1);
    check("R7 irq_req disabled", irq_req, 0);
    check("R7 aux_req disabled", aux_req, 0);
    wr(1'b0, 3'b001); wr(1'b1, 3'b001);
    check("R7 irq_req after enable", irq_req, 1);
    check("R7 aux_req after enable", aux_req, 1);

    // R6 edge and acknowledge in the same cycle
    irq_pin_n = 1'b1; aux_pin = 1'b1;
    tick(4);
    irq_pin_n = 1'b0; aux_pin = 1'b0;
    tick(2);
    wr(1'b0, 3'b101);
    rd(1'b0, d); check("R6 main set beats ack", d[1], 1);
    irq_pin_n = 1'b1; aux_pin = 1'b1;
    tick(4);
    aux_pin = 1'b0;
    tick(2);
    wr(1'b1, 3'b101);
    rd(1'b1, d); check("R6 aux set beats ack", d[1], 1);
    wr(1'b0, 3'b101); wr(1'b1, 3'b101);
    rd(1'b0, d); check("R6 lone main ack", d[1], 0);
    rd(1'b1, d); check("R6 lone aux ack", d[1], 0);

    // R5 merged events
    cfg_kbd_en = 1'b1;
    do_reset();
    wr(1'b0, 3'b001);
    irq_pin_n = 1'b0; kbd_pins = '1;
    tick(4);
    rd(1'b0, d); check("R5 merged flag", d[1], 1);
    wr(1'b0, 3'b101);
    tick(4);
    rd(1'b0, d); check("R5 single event", d[1], 0);
    irq_pin_n = 1'b1; kbd_pins = '0;
    tick(4);
    kbd_pins[0] = 1'b1;
    tick(4);
    rd(1'b0, d); check("R5 first key", d[1], 1);
    wr(1'b0, 3'b101);
    kbd_pins[1] = 1'b1;
    tick(4);
    rd(1'b0, d); check("R5 second key while active", d[1], 0);
    check("R5 irq_req quiet", irq_req, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule